// File: doc/BRIEF.md
# Modem Status Generator with Loopback Crossover

This block produces the 8-bit modem-status value of a serial port from the port's modem-control value. When the control value selects loopback, the four control outputs are routed back as the four status inputs through a fixed crossover. Outside loopback, the status reports carrier detect and data-set-ready as permanently asserted, and clear-to-send and ring as deasserted.

The upper four bits of the status value are the line states. The lower four bits are sticky change flags. On each control write the block compares the new line states with the current ones and sets the matching change flags. A read strobe clears the change flags. A single output, `delta_pending`, tells the interrupt logic that at least one change flag is set.

The surrounding register file masks the control value to five bits before it reaches this block. It raises `ctl_wr` for one cycle on a control write and `stat_rd` for one cycle on a status read, and it samples `stat_q` in the same cycle as the read strobe.

Top module: `modem_status_unit`

## Requirements
- R1: With loopback selected (`ctl_val[4]`=1), the next status line bits are CTS (bit 4) = `ctl_val[1]`, DSR (bit 5) = `ctl_val[0]`, RI (bit 6) = `ctl_val[2]` and DCD (bit 7) = `ctl_val[3]`.
- R2: With `ctl_val[4]`=0, a control write leaves status bits [7:4] at 4'b1010 (DCD and DSR set, RI and CTS clear).
- R3: On a control write, a change in CTS, DSR or DCD sets its change flag: bit 0 for CTS, bit 1 for DSR, bit 3 for DCD. The flag appears in the cycle after the write.
- R4: The ring change flag (bit 2) is set only when RI falls from 1 to 0 on a control write. A rising RI leaves it clear.
- R5: A control write keeps change flags that are already set while it replaces the line bits. With no strobe, the status value holds.
- R6: A read strobe presents the current value on `stat_q` during the strobe cycle and clears bits [3:0] in the following cycle.
- R7: During reset, the status value becomes the line mapping of the `ctl_val` present at reset, with all change flags clear. With `ctl_val`=0 this is 8'hA0.
- R8: `delta_pending` is 1 exactly when some bit of `stat_q[3:0]` is 1.
- R9: When a read and a control write fall in the same cycle, the change flags raised by that write survive, and only flags that were set before that cycle are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_val | input | 5 | Masked modem-control value: [0] DTR, [1] RTS, [2] OUT1, [3] OUT2, [4] loopback |
| ctl_wr | input | 1 | Control write strobe, one cycle |
| stat_rd | input | 1 | Status read strobe, one cycle |
| stat_q | output | 8 | Status value: [3:0] change flags, [7:4] CTS, DSR, RI, DCD |
| delta_pending | output | 1 | At least one change flag is set |

## Verification
A control write and a status read can land in the same cycle. In that cycle the clear of the change flags competes with the flags the write raises. The bench first builds up a pending ring flag. It then issues one cycle carrying both strobes, with a control value that drops RTS. It checks that the old ring flag is gone and the new CTS flag remains, and that the value shown during the strobe cycle is still the pre-clear one.

// File: rtl/mstat_pkg.sv
// Package: shared widths, field positions and the loopback crossover
// function for the modem-status generator.
// Assumes the control value is already masked to CTL_W bits by its owner.
package mstat_pkg;
    parameter int CTL_W  = 5;
    parameter int STAT_W = 8;
    parameter int HALF_W = STAT_W / 2;

    // Control field positions (the crossover depends on them)
    localparam int C_DTR  = 0;
    localparam int C_RTS  = 1;
    localparam int C_OUT1 = 2;
    localparam int C_OUT2 = 3;
    localparam int C_LOOP = 4;

    // Line-state positions within the upper half (offset by HALF_W)
    localparam int L_CTS = 0;
    localparam int L_DSR = 1;
    localparam int L_RI  = 2;
    localparam int L_DCD = 3;

    // Change-flag positions within the lower half
    localparam int D_CTS = 0;
    localparam int D_DSR = 1;
    localparam int D_RI  = 2;
    localparam int D_DCD = 3;

    typedef logic [HALF_W-1:0] nib_t;

    // Maps a control value to the four line states.
    function automatic nib_t ctl_to_lines(input logic [CTL_W-1:0] c);
        nib_t l;
        l = '0;
        if (c[C_LOOP]) begin
            l[L_CTS] = c[C_RTS];
            l[L_DSR] = c[C_DTR];
            l[L_RI]  = c[C_OUT1];
            l[L_DCD] = c[C_OUT2];
        end else begin
            l[L_DSR] = 1'b1;
            l[L_DCD] = 1'b1;
        end
        return l;
    endfunction
endpackage

// File: rtl/mstat_line_map.sv
// Module: mstat_line_map
// Combinational crossover from the control value to the four line states.
// Assumes: ctl_val is stable whenever it is sampled by the status register.
module mstat_line_map
    import mstat_pkg::*;
(
    input  logic [CTL_W-1:0] ctl_val,
    output nib_t             lines
);
    // Purpose: apply loopback crossover or the fixed normal-mode levels
    always_comb begin
        lines = ctl_to_lines(ctl_val);
    end
endmodule

// File: rtl/mstat_delta_det.sv
// Module: mstat_delta_det
// Compares the current line states with the incoming ones and raises the
// change flags a control write would set. It has no state of its own.
// Assumes: raise is consumed only when the write strobe is high.
module mstat_delta_det
    import mstat_pkg::*;
(
    input  nib_t cur_lines,
    input  nib_t new_lines,
    output nib_t raise
);
    localparam int N_LEVEL = 3;
    localparam int LVL_LINE [N_LEVEL] = '{L_CTS, L_DSR, L_DCD};
    localparam int LVL_FLAG [N_LEVEL] = '{D_CTS, D_DSR, D_DCD};

    logic [N_LEVEL-1:0] lvl_chg;

    // Purpose: level-change detection for CTS, DSR and DCD
    for (genvar g = 0; g < N_LEVEL; g++) begin : g_lvl
        assign lvl_chg[g] = cur_lines[LVL_LINE[g]] ^ new_lines[LVL_LINE[g]];
    end

    // Purpose: assemble flags, ring flag only on a falling edge
    always_comb begin
        raise = '0;
        for (int i = 0; i < N_LEVEL; i++) raise[LVL_FLAG[i]] = lvl_chg[i];
        raise[D_RI] = cur_lines[L_RI] & ~new_lines[L_RI];
    end
endmodule

// File: rtl/modem_status_unit.sv
// Module: modem_status_unit (top)
// Holds the modem-status value. The line bits are replaced on control
// writes. The change flags are sticky, are set by writes and are cleared
// by reads. A read in the same cycle as a write clears only older flags.
// Assumes: ctl_wr and stat_rd are single-cycle strobes from a register
// file that samples stat_q during the stat_rd cycle.
module modem_status_unit
    import mstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTL_W-1:0]  ctl_val,
    input  logic              ctl_wr,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_q,
    output logic              delta_pending
);
    nib_t lines_q, flags_q, lines_nx, raise;

    mstat_line_map u_map (
        .ctl_val (ctl_val),
        .lines   (lines_nx)
    );

    mstat_delta_det u_det (
        .cur_lines (lines_q),
        .new_lines (lines_nx),
        .raise     (raise)
    );

    // Purpose: status register update (reset, write, read-clear)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= lines_nx;
            flags_q <= '0;
        end else begin
            if (ctl_wr) lines_q <= lines_nx;
            flags_q <= (stat_rd ? '0 : flags_q) | (ctl_wr ? raise : '0);
        end
    end

    // Purpose: drive outputs
    assign stat_q        = {lines_q, flags_q};
    assign delta_pending = |flags_q;

    // R2
    normal_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_val[C_LOOP]) |=> (stat_q[7:4] == 4'b1010));
    // R3
    cts_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_val[C_LOOP] && (ctl_val[C_RTS] != stat_q[4])) |=> stat_q[0]);
    // R4
    ring_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && stat_q[6] && !(ctl_val[C_LOOP] && ctl_val[C_OUT1])) |=> stat_q[2]);
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && !stat_rd) |=> $stable(stat_q));
    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ctl_wr) |=> (stat_q[3:0] == 4'b0000));
    // R9
    rd_wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ctl_wr && !ctl_val[C_LOOP] && stat_q[6]) |=> stat_q[2]);
endmodule

// File: tb/modem_status_unit_test.sv
module modem_status_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ctl_val = '0;
    logic       ctl_wr = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_q;
    logic       delta_pending;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    modem_status_unit uut (
        .clk(clk), .rst_n(rst_n), .ctl_val(ctl_val), .ctl_wr(ctl_wr),
        .stat_rd(stat_rd), .stat_q(stat_q), .delta_pending(delta_pending)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One strobe cycle, then sample at the next falling edge
    task automatic do_write(input logic [4:0] v);
        @(negedge clk); ctl_val = v; ctl_wr = 1'b1;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic t_reset;
        check("R7 reset value", stat_q, 8'hA0);
        check("R8 pending at reset", {7'd0, delta_pending}, 8'h00);
    endtask

    task automatic t_normal;
        do_write(5'h03);
        check("R2 normal lines", stat_q, 8'hA0);
        check("R8 no pending", {7'd0, delta_pending}, 8'h00);
    endtask

    task automatic t_loop_all_low;
        do_write(5'h10);
        check("R3 DSR/DCD flags", stat_q, 8'h0A);
        check("R8 pending set", {7'd0, delta_pending}, 8'h01);
    endtask

    task automatic t_read;
        logic [7:0] seen;
        @(negedge clk); stat_rd = 1'b1; seen = stat_q;
        @(negedge clk); stat_rd = 1'b0;
        check("R6 value during read", seen, 8'h0A);
        check("R6 cleared after read", stat_q, 8'h00);
        check("R8 pending cleared", {7'd0, delta_pending}, 8'h00);
    endtask

    task automatic t_loop_all_high;
        do_write(5'h1F);
        check("R1 R4 crossover, no ring flag on rise", stat_q, 8'hFB);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        check("R6 flags cleared", stat_q, 8'hF0);
    endtask

    task automatic t_ring_fall;
        do_write(5'h1B);
        check("R4 ring falling edge", stat_q, 8'hB4);
        do_write(5'h1B);
        check("R5 flag kept on write", stat_q, 8'hB4);
        @(negedge clk); @(negedge clk);
        check("R5 hold idle", stat_q, 8'hB4);
    endtask

    task automatic t_same_cycle;
        logic [7:0] seen;
        @(negedge clk); ctl_val = 5'h19; ctl_wr = 1'b1; stat_rd = 1'b1; seen = stat_q;
        @(negedge clk); ctl_wr = 1'b0; stat_rd = 1'b0;
        check("R9 value during strobe", seen, 8'hB4);
        check("R9 new flag kept, old cleared", stat_q, 8'hA1);
    endtask

    task automatic t_dtr_only;
        do_write(5'h11);
        check("R1 DTR to DSR", stat_q, 8'h29);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_loop_all_low();
        t_read();
        t_loop_all_high();
        t_ring_fall();
        t_same_cycle();
        t_dtr_only();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule